// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words enter on the write clock when the write select and write enable are both low, and leave on the read clock when the read select and read enable are both low. Each side keeps a binary pointer one bit wider than the array address and passes it to the other side as Gray code through a two-stage synchronizer. Each side then works out its own view of the fill level and registers its flags on its own clock only. The write side drives an active-low full flag and an active-low almost-full flag. The read side drives an active-low empty flag and an active-low almost-empty flag. The two thresholds come from the offset parameters `AF_OFFSET` (m) and `AE_OFFSET` (n), with n + m < D, where D = 2^`ADDR_W`.

A static input selects the read behaviour, and it may change only while reset is held. In standard mode a read request loads the oldest word into the output register. In look-ahead mode the oldest word is moved into the output register without a request and marked by `out_valid`, and a read request then consumes it. The output register counts as one more storage place, so the FIFO holds D + 1 words and the almost-empty threshold is one word higher.

The write side runs the state machine FILL_ROOM / FILL_NEAR / FILL_FULL. Its transitions are ROOM→NEAR (the write that reaches D−m), NEAR→FULL (the write that reaches D), and the release steps FULL→NEAR, NEAR→ROOM and FULL→ROOM once the synchronized read pointer shows space. The read side runs the output-stage machine OS_VACANT / OS_PRIMED / OS_STD. Its transitions are VACANT→STD (mode select after reset in standard mode), VACANT→PRIMED (fetch of the first word), PRIMED→PRIMED (a read with a refill), and PRIMED→VACANT (a read that leaves the array empty).

Top module: `pflag_async_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers are cleared and the outputs are `full_n`=1, `almost_full_n`=1, `empty_n`=0, `almost_empty_n`=0, `out_valid`=0 and `rd_data`=0.
- R2: A read is taken only at a rising `rclk` edge that sees `rd_cs_n`=0, `rd_en_n`=0 and a non-empty read side: `empty_n`=1 in standard mode, `out_valid`=1 in look-ahead mode. Any other read attempt is ignored and `rd_data` keeps its value.
- R3: In standard mode, every taken read places the oldest unread word on `rd_data` at the read edge, and words leave in the order they were written.
- R4: A write is taken only at a rising `wclk` edge that sees `wr_cs_n`=0, `wr_en_n`=0 and `full_n`=1. `full_n` is low while the array holds D words, and a write attempted then changes nothing.
- R5: `almost_full_n` is low when the array count c satisfies c ≥ D−m, and high when c ≤ D−m−1. It changes only on `wclk`, and it falls at the write edge that brings c up to D−m.
- R6: After a read edge takes the array count below D−m, `almost_full_n` rises at the third following `wclk` rising edge. Two of those edges are for the synchronizer and one is for the flag register. An edge that arrives closer than setup time can add one more.
- R7: Let t be the total stored count, that is, the array words plus a word held in the look-ahead output register. `almost_empty_n` is low when t ≤ n in standard mode or t ≤ n+1 in look-ahead mode, and high otherwise. It changes only on `rclk` and falls only at a read edge.
- R8: After a write edge takes t above the threshold, `almost_empty_n` rises at the third following `rclk` rising edge, with the same possible extra edge as in R6.
- R9: With `fwft_mode`=1, the oldest word appears on `rd_data` with `out_valid`=1 and no read request. It stays there until a read takes it. `empty_n` equals `out_valid`, and the FIFO holds D+1 words.
- R10: In standard mode, once both sides have been idle long enough for the pointers to cross, `empty_n` is high exactly when the array holds at least one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| fwft_mode | input | 1 | 1 = look-ahead read mode, 0 = standard; change only while reset is held |
| wr_cs_n | input | 1 | Active-low write select |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | DATA_W | Word to store |
| rd_cs_n | input | 1 | Active-low read select |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | DATA_W | Output register |
| full_n | output | 1 | Active-low full flag, `wclk` domain |
| almost_full_n | output | 1 | Active-low programmable almost-full flag, `wclk` domain |
| empty_n | output | 1 | Active-low empty flag, `rclk` domain |
| almost_empty_n | output | 1 | Active-low programmable almost-empty flag, `rclk` domain |
| out_valid | output | 1 | Look-ahead word present on `rd_data` |

## Verification
Some results are due at the edge of the stimulus itself: the standard-mode `rd_data`, the fall of `almost_full_n` on a write, and the fall of `almost_empty_n` on a read. The bench samples these at the falling edge that follows. A flag that depends on the far side's pointer is due three own-domain edges after the causing edge. The release tests count those edges one by one and expect exactly three. For every other flag check the bench first holds both ports idle for at least six cycles of each clock and then compares all flags against counts taken from its own model queue. In look-ahead mode the head word is compared on every read-clock falling edge at which `out_valid` is high.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    typedef enum logic [1:0] {
        FILL_ROOM,
        FILL_NEAR,
        FILL_FULL
    } fill_state_t;

    typedef enum logic [1:0] {
        OS_VACANT,
        OS_PRIMED,
        OS_STD
    } out_state_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage[i] <= '0;
            end
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/afifo_store.sv
module afifo_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              rd_load,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (wr_fire) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_load) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl
    import afifo_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int AF_OFFSET = 3
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              wr_cs_n,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wbin,
    output logic [ADDR_W:0]   wgray,
    output logic              full_n,
    output logic              almost_full_n
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] NEAR_CNT = PTR_W'(DEPTH - AF_OFFSET);

    fill_state_t      st, st_nxt;
    logic [PTR_W-1:0] wbin_nxt;
    logic [PTR_W-1:0] rbin_sync;
    logic [PTR_W-1:0] used_nxt;

    // Write acceptance and post-edge fill level
    always_comb begin
        wr_fire   = !wr_en_n && !wr_cs_n && (st != FILL_FULL);
        wbin_nxt  = wbin + PTR_W'(wr_fire);
        rbin_sync = PTR_W'(gray_to_bin(32'(rgray_sync)));
        used_nxt  = wbin_nxt - rbin_sync;
    end

    // Next fill state
    always_comb begin
        st_nxt = st;
        unique case (st)
            FILL_ROOM: begin
                if (used_nxt == FULL_CNT)      st_nxt = FILL_FULL;
                else if (used_nxt >= NEAR_CNT) st_nxt = FILL_NEAR;
            end
            FILL_NEAR: begin
                if (used_nxt == FULL_CNT)      st_nxt = FILL_FULL;
                else if (used_nxt < NEAR_CNT)  st_nxt = FILL_ROOM;
            end
            FILL_FULL: begin
                if (used_nxt < NEAR_CNT)       st_nxt = FILL_ROOM;
                else if (used_nxt != FULL_CNT) st_nxt = FILL_NEAR;
            end
            default: st_nxt = FILL_ROOM;
        endcase
    end

    // State and pointer register
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= FILL_ROOM;
            wbin  <= '0;
            wgray <= '0;
        end else begin
            st    <= st_nxt;
            wbin  <= wbin_nxt;
            wgray <= PTR_W'(bin_to_gray(32'(wbin_nxt)));
        end
    end

    // Flag decode
    always_comb begin
        waddr = wbin[ADDR_W-1:0];
        unique case (st)
            FILL_ROOM: begin full_n = 1'b1; almost_full_n = 1'b1; end
            FILL_NEAR: begin full_n = 1'b1; almost_full_n = 1'b0; end
            FILL_FULL: begin full_n = 1'b0; almost_full_n = 1'b0; end
            default:   begin full_n = 1'b1; almost_full_n = 1'b1; end
        endcase
    end

endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl
    import afifo_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int AE_OFFSET = 2
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              fwft_mode,
    input  logic              rd_en_n,
    input  logic              rd_cs_n,
    input  logic [ADDR_W:0]   wgray_sync,
    output logic              rd_load,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rbin,
    output logic [ADDR_W:0]   rgray,
    output logic              empty_n,
    output logic              almost_empty_n,
    output logic              out_valid
);

    localparam int PTR_W = ADDR_W + 1;
    localparam int CNT_W = ADDR_W + 2;

    out_state_t       st, st_nxt;
    logic             port_req;
    logic             mem_ne;
    logic             empty_q;
    logic             ae_q;
    logic [PTR_W-1:0] wbin_sync;
    logic [PTR_W-1:0] rbin_nxt;
    logic [PTR_W-1:0] mem_nxt;
    logic [CNT_W-1:0] total_nxt;
    logic [CNT_W-1:0] ae_limit;

    // Output-stage transitions and array fetch
    always_comb begin
        port_req  = !rd_en_n && !rd_cs_n;
        wbin_sync = PTR_W'(gray_to_bin(32'(wgray_sync)));
        mem_ne    = (wbin_sync != rbin);
        st_nxt    = st;
        rd_load   = 1'b0;
        unique case (st)
            OS_VACANT: begin
                if (!fwft_mode) begin
                    st_nxt = OS_STD;
                end else if (mem_ne) begin
                    rd_load = 1'b1;
                    st_nxt  = OS_PRIMED;
                end
            end
            OS_PRIMED: begin
                if (port_req) begin
                    if (mem_ne) rd_load = 1'b1;
                    else        st_nxt  = OS_VACANT;
                end
            end
            OS_STD: begin
                rd_load = port_req && empty_q;
            end
            default: st_nxt = OS_VACANT;
        endcase
        rbin_nxt  = rbin + PTR_W'(rd_load);
        mem_nxt   = wbin_sync - rbin_nxt;
        total_nxt = CNT_W'(mem_nxt) + CNT_W'(st_nxt == OS_PRIMED);
        ae_limit  = CNT_W'(AE_OFFSET) + CNT_W'(fwft_mode);
    end

    // State, pointer and read-side flag register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= OS_VACANT;
            rbin    <= '0;
            rgray   <= '0;
            empty_q <= 1'b0;
            ae_q    <= 1'b0;
        end else begin
            st      <= st_nxt;
            rbin    <= rbin_nxt;
            rgray   <= PTR_W'(bin_to_gray(32'(rbin_nxt)));
            empty_q <= (mem_nxt != '0);
            ae_q    <= !(total_nxt <= ae_limit);
        end
    end

    // Output decode
    always_comb begin
        raddr          = rbin[ADDR_W-1:0];
        out_valid      = (st == OS_PRIMED);
        empty_n        = fwft_mode ? out_valid : empty_q;
        almost_empty_n = ae_q;
    end

endmodule

// File: rtl/pflag_async_fifo.sv
module pflag_async_fifo #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 4,
    parameter int AF_OFFSET = 3,
    parameter int AE_OFFSET = 2
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              fwft_mode,
    input  logic              wr_cs_n,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_cs_n,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              full_n,
    output logic              almost_full_n,
    output logic              empty_n,
    output logic              almost_empty_n,
    output logic              out_valid
);

    localparam int PTR_W       = ADDR_W + 1;
    localparam int SYNC_STAGES = 2;

    logic              wr_fire;
    logic              rd_load;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PTR_W-1:0]  wptr_bin;
    logic [PTR_W-1:0]  rptr_bin;
    logic [PTR_W-1:0]  wgray;
    logic [PTR_W-1:0]  rgray;
    logic [PTR_W-1:0]  wgray_rs;
    logic [PTR_W-1:0]  rgray_ws;

    afifo_wr_ctl #(
        .ADDR_W    (ADDR_W),
        .AF_OFFSET (AF_OFFSET)
    ) u_wr (
        .wclk          (wclk),
        .rst_n         (rst_n),
        .wr_en_n       (wr_en_n),
        .wr_cs_n       (wr_cs_n),
        .rgray_sync    (rgray_ws),
        .wr_fire       (wr_fire),
        .waddr         (waddr),
        .wbin          (wptr_bin),
        .wgray         (wgray),
        .full_n        (full_n),
        .almost_full_n (almost_full_n)
    );

    afifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_ws)
    );

    afifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_rs)
    );

    afifo_rd_ctl #(
        .ADDR_W    (ADDR_W),
        .AE_OFFSET (AE_OFFSET)
    ) u_rd (
        .rclk           (rclk),
        .rst_n          (rst_n),
        .fwft_mode      (fwft_mode),
        .rd_en_n        (rd_en_n),
        .rd_cs_n        (rd_cs_n),
        .wgray_sync     (wgray_rs),
        .rd_load        (rd_load),
        .raddr          (raddr),
        .rbin           (rptr_bin),
        .rgray          (rgray),
        .empty_n        (empty_n),
        .almost_empty_n (almost_empty_n),
        .out_valid      (out_valid)
    );

    afifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wclk    (wclk),
        .wr_fire (wr_fire),
        .waddr   (waddr),
        .wdata   (wr_data),
        .rclk    (rclk),
        .rst_n   (rst_n),
        .rd_load (rd_load),
        .raddr   (raddr),
        .rdata   (rd_data)
    );

endmodule

// File: rtl/pflag_async_fifo_checker.sv
module afifo_flag_checker #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 5
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              fwft_mode,
    input logic              wr_cs_n,
    input logic              wr_en_n,
    input logic              rd_cs_n,
    input logic              rd_en_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              full_n,
    input logic              almost_full_n,
    input logic              empty_n,
    input logic              almost_empty_n,
    input logic              out_valid,
    input logic [PTR_W-1:0]  wptr_bin,
    input logic [PTR_W-1:0]  rptr_bin
);

    // R4: a write attempted while full leaves the write pointer alone
    p_no_overflow_r4: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && !wr_en_n && !wr_cs_n) |=> $stable(wptr_bin));

    // R2: in standard mode an empty read side never advances the read pointer
    p_no_underflow_r2: assert property (@(posedge rclk) disable iff (!rst_n)
        (!fwft_mode && !empty_n) |=> $stable(rptr_bin));

    // R5: almost-full only falls at an edge that carried a write request
    p_af_fall_on_write_r5: assert property (@(posedge wclk) disable iff (!rst_n)
        $fell(almost_full_n) |-> $past(!wr_en_n && !wr_cs_n));

    // R7: almost-empty only falls at an edge that carried a read request
    p_ae_fall_on_read_r7: assert property (@(posedge rclk) disable iff (!rst_n)
        $fell(almost_empty_n) |-> $past(!rd_en_n && !rd_cs_n));

    // R9: a look-ahead word stays put until a read takes it
    p_fwft_hold_r9: assert property (@(posedge rclk) disable iff (!rst_n)
        (fwft_mode && out_valid && (rd_en_n || rd_cs_n)) |=> (out_valid && $stable(rd_data)));

endmodule

bind pflag_async_fifo afifo_flag_checker #(
    .DATA_W (DATA_W),
    .PTR_W  (ADDR_W + 1)
) u_flag_chk (
    .wclk           (wclk),
    .rclk           (rclk),
    .rst_n          (rst_n),
    .fwft_mode      (fwft_mode),
    .wr_cs_n        (wr_cs_n),
    .wr_en_n        (wr_en_n),
    .rd_cs_n        (rd_cs_n),
    .rd_en_n        (rd_en_n),
    .rd_data        (rd_data),
    .full_n         (full_n),
    .almost_full_n  (almost_full_n),
    .empty_n        (empty_n),
    .almost_empty_n (almost_empty_n),
    .out_valid      (out_valid),
    .wptr_bin       (wptr_bin),
    .rptr_bin       (rptr_bin)
);

// File: tb/pflag_async_fifo_test.sv
module pflag_async_fifo_test;

    localparam int DW  = 8;
    localparam int AW  = 4;
    localparam int D   = 1 << AW;
    localparam int AFO = 3;
    localparam int AEO = 2;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft_mode = 1'b0;
    logic          wr_cs_n = 1'b1;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_cs_n = 1'b1;
    logic          rd_en_n = 1'b1;
    logic [DW-1:0] rd_data;
    logic          full_n, almost_full_n, empty_n, almost_empty_n, out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int q[$];
    bit pend = 0;
    int pend_val = 0;

    always #5 wclk = ~wclk;                 // 100 MHz write clock
    initial begin
        #1;
        forever #7 rclk = ~rclk;            // unrelated read clock
    end

    pflag_async_fifo #(
        .DATA_W(DW), .ADDR_W(AW), .AF_OFFSET(AFO), .AE_OFFSET(AEO)
    ) uut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_mode(fwft_mode),
        .wr_cs_n(wr_cs_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .rd_cs_n(rd_cs_n), .rd_en_n(rd_en_n), .rd_data(rd_data),
        .full_n(full_n), .almost_full_n(almost_full_n), .empty_n(empty_n),
        .almost_empty_n(almost_empty_n), .out_valid(out_valid)
    );

    task automatic check_eq(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int exp_full_n(input int memc);
        return (memc == D) ? 0 : 1;
    endfunction
    function automatic int exp_af_n(input int memc);
        return (memc >= D - AFO) ? 0 : 1;
    endfunction
    function automatic int exp_ae_n(input int tot, input bit la);
        return (tot <= AEO + int'(la)) ? 0 : 1;
    endfunction

    task automatic wr_cycle(input bit en, input bit cs, input logic [DW-1:0] d);
        @(negedge wclk);
        wr_en_n = !en;
        wr_cs_n = !cs;
        wr_data = d;
        if (en && cs && full_n) q.push_back(int'(d));
    endtask

    task automatic rd_cycle(input bit en, input bit cs);
        @(negedge rclk);
        if (pend) begin
            check_eq("R3 standard read word", int'(rd_data), pend_val);
            pend = 0;
        end
        if (fwft_mode) begin
            if (out_valid) begin
                if (q.size() == 0) check_eq("R9 word shown with empty model", 1, 0);
                else check_eq("R9 head word on rd_data", int'(rd_data), q[0]);
                if (en && cs && q.size() > 0) void'(q.pop_front());
            end
        end else if (en && cs && empty_n) begin
            if (q.size() == 0) check_eq("R2 read taken with empty model", 1, 0);
            else begin
                pend_val = q.pop_front();
                pend = 1;
            end
        end
        rd_en_n = !en;
        rd_cs_n = !cs;
    endtask

    task automatic settle();
        fork
            begin repeat (8) wr_cycle(0, 0, '0); end
            begin repeat (8) rd_cycle(0, 0); end
        join
    endtask

    task automatic check_flags(input string tag);
        int tot;
        int memc;
        tot  = q.size();
        memc = (fwft_mode && tot > 0) ? tot - 1 : tot;
        check_eq({"R4 full_n ", tag}, int'(full_n), exp_full_n(memc));
        check_eq({"R5 almost_full_n ", tag}, int'(almost_full_n), exp_af_n(memc));
        check_eq({"R7 almost_empty_n ", tag}, int'(almost_empty_n), exp_ae_n(tot, fwft_mode));
        if (fwft_mode) begin
            check_eq({"R9 out_valid ", tag}, int'(out_valid), (tot > 0) ? 1 : 0);
            check_eq({"R9 empty_n ", tag}, int'(empty_n), int'(out_valid));
        end else begin
            check_eq({"R10 empty_n ", tag}, int'(empty_n), (tot > 0) ? 1 : 0);
        end
    endtask

    task automatic do_reset(input bit la);
        rst_n = 1'b0;
        fwft_mode = la;
        wr_en_n = 1'b1; wr_cs_n = 1'b1;
        rd_en_n = 1'b1; rd_cs_n = 1'b1;
        q.delete();
        pend = 0;
        repeat (3) @(posedge wclk);
        #1;
        check_eq("R1 full_n in reset", int'(full_n), 1);
        check_eq("R1 almost_full_n in reset", int'(almost_full_n), 1);
        check_eq("R1 empty_n in reset", int'(empty_n), 0);
        check_eq("R1 almost_empty_n in reset", int'(almost_empty_n), 0);
        check_eq("R1 out_valid in reset", int'(out_valid), 0);
        check_eq("R1 rd_data in reset", int'(rd_data), 0);
        @(negedge wclk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic fill_sweep(input bit la);
        int top;
        do_reset(la);
        top = la ? D + 1 : D;
        for (int k = 0; k <= top + 1; k++) begin
            check_flags($sformatf("fill step %0d", k));
            wr_cycle(1, 1, DW'(8'hA0 + k));
            wr_cycle(0, 0, '0);
            settle();
        end
        check_eq("R4 stored count capped", q.size(), top);
        for (int k = 0; k <= top; k++) begin
            rd_cycle(1, 1);
            rd_cycle(0, 0);
            settle();
            check_flags($sformatf("drain step %0d", k));
        end
    endtask

    task automatic random_run(input bit la, input int n);
        do_reset(la);
        fork
            begin
                for (int i = 0; i < n; i++)
                    wr_cycle(($urandom % 10) < 6, ($urandom % 10) < 9, DW'($urandom));
                wr_cycle(0, 0, '0);
            end
            begin
                for (int i = 0; i < n; i++)
                    rd_cycle(($urandom % 10) < 5, ($urandom % 10) < 9);
                rd_cycle(0, 0);
            end
        join
        settle();
        check_flags("after random traffic");
        repeat (D + 4) rd_cycle(1, 1);
        rd_cycle(0, 0);
        settle();
        check_flags("after random drain");
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog R1-chain timeout actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd1234));

        // Empty reads and deselected accesses are ignored (standard mode)
        do_reset(1'b0);
        repeat (3) rd_cycle(1, 1);
        rd_cycle(0, 0);
        check_eq("R2 rd_data kept after empty reads", int'(rd_data), 0);
        wr_cycle(1, 0, 8'h11);
        wr_cycle(0, 1, 8'h12);
        wr_cycle(1, 1, 8'h33);
        wr_cycle(1, 1, 8'h44);
        wr_cycle(0, 0, '0);
        settle();
        check_eq("R4 deselected writes ignored", q.size(), 2);
        check_flags("two words");
        rd_cycle(1, 0);
        rd_cycle(0, 1);
        rd_cycle(0, 0);
        check_eq("R2 deselected read keeps rd_data", int'(rd_data), 0);
        rd_cycle(1, 1);
        rd_cycle(1, 1);
        rd_cycle(0, 0);
        settle();
        check_flags("emptied again");

        // R6: almost-full release latency
        do_reset(1'b0);
        for (int k = 0; k < D - AFO; k++) wr_cycle(1, 1, DW'(k + 1));
        wr_cycle(0, 0, '0);
        settle();
        check_eq("R6 almost_full_n before read", int'(almost_full_n), 0);
        rd_cycle(1, 1);
        @(posedge rclk);
        #1;
        rd_en_n = 1'b1; rd_cs_n = 1'b1;
        n = 0;
        while (almost_full_n == 1'b0 && n < 8) begin
            @(posedge wclk);
            #1;
            n++;
        end
        check_eq("R6 wclk edges to almost_full_n release", n, 3);
        rd_cycle(0, 0);
        settle();
        check_flags("after R6");

        // R8: almost-empty release latency
        do_reset(1'b0);
        for (int k = 0; k < AEO; k++) wr_cycle(1, 1, DW'(k + 8'h40));
        wr_cycle(0, 0, '0);
        settle();
        check_eq("R8 almost_empty_n before write", int'(almost_empty_n), 0);
        wr_cycle(1, 1, 8'h4F);
        @(posedge wclk);
        #1;
        wr_en_n = 1'b1; wr_cs_n = 1'b1;
        n = 0;
        while (almost_empty_n == 1'b0 && n < 8) begin
            @(posedge rclk);
            #1;
            n++;
        end
        check_eq("R8 rclk edges to almost_empty_n release", n, 3);
        settle();
        check_flags("after R8");

        // R9: first word falls through without a read request
        do_reset(1'b1);
        wr_cycle(1, 1, 8'h5A);
        wr_cycle(0, 0, '0);
        n = 0;
        while (out_valid == 1'b0 && n < 10) begin
            rd_cycle(0, 0);
            n++;
        end
        check_eq("R9 out_valid without request", int'(out_valid), 1);
        check_eq("R9 fall-through word", int'(rd_data), 8'h5A);
        rd_cycle(1, 1);
        rd_cycle(0, 0);
        settle();
        check_flags("after fall-through read");

        // Threshold sweeps in both modes
        fill_sweep(1'b0);
        fill_sweep(1'b1);

        // Random traffic in both modes
        random_run(1'b0, 600);
        random_run(1'b1, 600);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule